// File: doc/BRIEF.md
# Linear SIMD Lane Exchange Network

This block moves data between the lanes of a one-dimensional processing array in which every lane executes the same command on the same clock. Each lane owns one data word and a small local memory. Each lane is wired only to its left and right neighbours. A single controller issues one command per operation, and the network runs it in every lane at once.

Four operations are available. A load copies a fresh word into each lane. A shift moves every word one lane position up or down, and the end lane that has no neighbour on the feeding side takes a supplied edge value. A broadcast copies one chosen lane's word to all lanes. A direct write takes one source lane's word and stores it into the local memory of one destination lane, at a chosen address. Load, shift and broadcast finish in one clock. The direct write takes a fixed number of cycles. It raises a busy flag while it runs and ends with a done pulse.

A per-lane enable mask blocks the update in lanes that are switched off. All local memories share one read address, and every lane returns its word on that address, so the memories can be observed.

Top module: `simd_lane_xchg`

## Requirements
- R1: After reset every lane word, every local memory word, `busy` and `done` are zero.
- R2: A load (`cmd_op` = 0) accepted on a clock edge sets every enabled lane's word to its slice of `lane_din` on that edge. A disabled lane keeps its word.
- R3: A shift with `shift_up` = 1 (`cmd_op` = 1) gives every enabled lane i the former word of lane i-1 on the accepting edge. Lane 0 takes `edge_word`. The top lane's word is not wrapped around.
- R4: A shift with `shift_up` = 0 gives every enabled lane i the former word of lane i+1 on the accepting edge. Lane LANES-1 takes `edge_word`.
- R5: A broadcast (`cmd_op` = 2) gives every enabled lane the former word of lane `sel_src` on the accepting edge.
- R6: A lane whose `lane_en` bit is 0 when a command is accepted is not written by that command. For a direct write, the destination's enable bit is taken when the command is accepted. If that bit is 0, no memory word changes.
- R7: A direct write (`cmd_op` = 3) raises `busy` for exactly DW_LAT cycles. It then gives one `done` pulse of one cycle in the first cycle `busy` is low. On the same edge that raises `done`, it stores the word that lane `sel_src` held at acceptance into address `dw_addr` of lane `dw_dst`. No other memory word changes.
- R8: A command presented while `busy` is high is ignored. Lane words and memories stay unchanged by it.
- R9: On every edge, `mem_rdata` is loaded with each lane's memory word at `rd_addr`. A word written on an edge is seen from the next edge on.
- R10: A direct write leaves all lane words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 load, 1 shift, 2 broadcast, 3 direct write |
| shift_up | input | 1 | Shift direction: 1 toward higher lane index |
| edge_word | input | DW | Word fed into the end lane during a shift |
| sel_src | input | log2(LANES) | Source lane for broadcast and direct write |
| dw_dst | input | log2(LANES) | Destination lane for direct write |
| dw_addr | input | log2(DEPTH) | Destination memory address for direct write |
| lane_en | input | LANES | Per-lane enable mask |
| lane_din | input | LANES*DW | Load words, lane i at bits i*DW |
| lane_dout | output | LANES*DW | Current lane words, lane i at bits i*DW |
| rd_addr | input | log2(DEPTH) | Shared memory read address |
| mem_rdata | output | LANES*DW | Registered memory words of all lanes |
| busy | output | 1 | Direct write in progress |
| done | output | 1 | One-cycle pulse when a direct write completes |

## Verification
A wrong neighbour index or a lost edge value in the shift network shows on `lane_dout` one edge after the shift, in the end lanes or in a single interior lane. A wrong broadcast select shows as the same wrong word in every enabled lane. Faults in the direct-write sequencer show in two places: in the busy length and the done timing within a few cycles, or as a misplaced memory word one edge later through the shared read port. A mask or busy-gating fault shows as a changed word in a lane that had to hold its value, on the edge right after the command.

// File: rtl/simd_xchg_pkg.sv
package simd_xchg_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_SHIFT  = 2'd1,
    OP_BCAST  = 2'd2,
    OP_DWRITE = 2'd3
  } xchg_op_e;

  // Index of the lane that feeds lane 'lane' during a shift; -1 means edge.
  function automatic int feeder_lane(input int lane, input int lanes, input logic up);
    int f;
    f = up ? lane - 1 : lane + 1;
    if (f < 0 || f >= lanes) f = -1;
    return f;
  endfunction

  // Counter width needed to hold values 0..n.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lane_shift_net.sv
module lane_shift_net
  import simd_xchg_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 16
) (
  input  logic [LANES*DW-1:0] words_in,
  input  logic [DW-1:0]       edge_word,
  input  logic                shift_up,
  output logic [LANES*DW-1:0] words_out
);

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      localparam int UP_SRC = feeder_lane(gi, LANES, 1'b1);
      localparam int DN_SRC = feeder_lane(gi, LANES, 1'b0);
      logic [DW-1:0] up_word, dn_word;
      if (UP_SRC < 0) begin : g_up_edge
        assign up_word = edge_word;
      end else begin : g_up_nb
        assign up_word = words_in[UP_SRC*DW +: DW];
      end
      if (DN_SRC < 0) begin : g_dn_edge
        assign dn_word = edge_word;
      end else begin : g_dn_nb
        assign dn_word = words_in[DN_SRC*DW +: DW];
      end
      assign words_out[gi*DW +: DW] = shift_up ? up_word : dn_word;
    end
  endgenerate

endmodule

// File: rtl/lane_bcast_sel.sv
module lane_bcast_sel #(
  parameter int LANES = 64,
  parameter int DW    = 16,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*DW-1:0] words_in,
  input  logic [LW-1:0]       src,
  output logic [DW-1:0]       word_out
);

  always_comb begin
    word_out = '0;
    for (int i = 0; i < LANES; i++) begin
      if (src == LW'(i)) word_out = words_in[i*DW +: DW];
    end
  end

endmodule

// File: rtl/dwrite_seq.sv
module dwrite_seq
  import simd_xchg_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int DW_LAT = 3,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = cnt_bits(DW_LAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    src_word,
  input  logic [LW-1:0]    dst,
  input  logic [AW-1:0]    addr,
  input  logic             dst_en,
  output logic             busy,
  output logic             done,
  output logic [LANES-1:0] wr_hit,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data
);

  logic [CW-1:0] cnt_q;
  logic [LW-1:0] dst_q;
  logic          en_q;
  logic          last_cycle;

  assign last_cycle = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt_q   <= '0;
      dst_q   <= '0;
      en_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cnt_q   <= CW'(DW_LAT - 1);
          dst_q   <= dst;
          en_q    <= dst_en;
          wr_addr <= addr;
          wr_data <= src_word;
        end
      end else if (last_cycle) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    wr_hit = '0;
    for (int i = 0; i < LANES; i++) begin
      if (last_cycle && en_q && dst_q == LW'(i)) wr_hit[i] = 1'b1;
    end
  end

endmodule

// File: rtl/lane_mem_bank.sv
module lane_mem_bank #(
  parameter int LANES = 64,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    wr_hit,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*DW-1:0] rd_data
);

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
          rd_data[gi*DW +: DW] <= '0;
        end else begin
          rd_data[gi*DW +: DW] <= mem[rd_addr];
          if (wr_hit[gi]) mem[wr_addr] <= wr_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/simd_lane_xchg.sv
module simd_lane_xchg
  import simd_xchg_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int DW_LAT = 3,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic                shift_up,
  input  logic [DW-1:0]       edge_word,
  input  logic [LW-1:0]       sel_src,
  input  logic [LW-1:0]       dw_dst,
  input  logic [AW-1:0]       dw_addr,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES*DW-1:0] lane_din,
  output logic [LANES*DW-1:0] lane_dout,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*DW-1:0] mem_rdata,
  output logic                busy,
  output logic                done
);

  xchg_op_e            op;
  logic                accept;
  logic                fire_load, fire_shift, fire_bcast, fire_dwrite;
  logic [LANES*DW-1:0] shifted_words;
  logic [DW-1:0]       bcast_word;
  logic                dst_en;
  logic [LANES-1:0]    wr_hit;
  logic [AW-1:0]       wr_addr;
  logic [DW-1:0]       wr_data;

  assign op          = xchg_op_e'(cmd_op);
  assign accept      = cmd_valid && !busy;
  assign fire_load   = accept && (op == OP_LOAD);
  assign fire_shift  = accept && (op == OP_SHIFT);
  assign fire_bcast  = accept && (op == OP_BCAST);
  assign fire_dwrite = accept && (op == OP_DWRITE);

  lane_shift_net #(.LANES(LANES), .DW(DW)) u_shift (
    .words_in  (lane_dout),
    .edge_word (edge_word),
    .shift_up  (shift_up),
    .words_out (shifted_words)
  );

  lane_bcast_sel #(.LANES(LANES), .DW(DW)) u_bcast (
    .words_in (lane_dout),
    .src      (sel_src),
    .word_out (bcast_word)
  );

  always_comb begin
    dst_en = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (dw_dst == LW'(i)) dst_en = lane_en[i];
    end
  end

  dwrite_seq #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH), .DW_LAT(DW_LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fire_dwrite),
    .src_word (bcast_word),
    .dst      (dw_dst),
    .addr     (dw_addr),
    .dst_en   (dst_en),
    .busy     (busy),
    .done     (done),
    .wr_hit   (wr_hit),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  lane_mem_bank #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (mem_rdata)
  );

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_dout[gi*DW +: DW] <= '0;
        end else if (lane_en[gi]) begin
          if (fire_load)       lane_dout[gi*DW +: DW] <= lane_din[gi*DW +: DW];
          else if (fire_shift) lane_dout[gi*DW +: DW] <= shifted_words[gi*DW +: DW];
          else if (fire_bcast) lane_dout[gi*DW +: DW] <= bcast_word;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/simd_lane_xchg_chk.sv
module simd_lane_xchg_chk #(
  parameter int LANES  = 64,
  parameter int DW     = 16,
  parameter int DW_LAT = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                fire_shift,
  input logic                fire_bcast,
  input logic                shift_up,
  input logic [DW-1:0]       edge_word,
  input logic [DW-1:0]       bcast_word,
  input logic [LANES-1:0]    lane_en,
  input logic [LANES-1:0]    wr_hit,
  input logic [LANES*DW-1:0] lane_dout
);

  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(DW_LAT)));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lane_dout));

  // R3
  low_edge_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_shift && shift_up && lane_en[0]) |=> (lane_dout[DW-1:0] == $past(edge_word)));

  // R4
  high_edge_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_shift && !shift_up && lane_en[LANES-1]) |=>
      (lane_dout[(LANES-1)*DW +: DW] == $past(edge_word)));

  // R5
  bcast_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_bcast && lane_en[0]) |=> (lane_dout[DW-1:0] == $past(bcast_word)));

endmodule

bind simd_lane_xchg simd_lane_xchg_chk #(.LANES(LANES), .DW(DW), .DW_LAT(DW_LAT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .fire_shift (fire_shift),
  .fire_bcast (fire_bcast),
  .shift_up   (shift_up),
  .edge_word  (edge_word),
  .bcast_word (bcast_word),
  .lane_en    (lane_en),
  .wr_hit     (wr_hit),
  .lane_dout  (lane_dout)
);

// File: tb/simd_lane_xchg_tb.sv
module simd_lane_xchg_tb_top;

  localparam int LANES  = 64;
  localparam int DW     = 16;
  localparam int DEPTH  = 8;
  localparam int DW_LAT = 3;
  localparam int LW     = $clog2(LANES);
  localparam int AW     = $clog2(DEPTH);
  localparam int VW     = LANES * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic          shift_up = 1'b0;
  logic [DW-1:0] edge_word = '0;
  logic [LW-1:0] sel_src = '0;
  logic [LW-1:0] dw_dst = '0;
  logic [AW-1:0] dw_addr = '0;
  logic [LANES-1:0] lane_en = '1;
  logic [VW-1:0] lane_din = '0;
  logic [VW-1:0] lane_dout;
  logic [AW-1:0] rd_addr = '0;
  logic [VW-1:0] mem_rdata;
  logic          busy, done;

  int checks = 0;
  int failures = 0;

  logic [VW-1:0] m_lanes;
  logic [DW-1:0] m_mem [LANES][DEPTH];

  always #2 clk = ~clk;

  simd_lane_xchg #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH), .DW_LAT(DW_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .shift_up(shift_up), .edge_word(edge_word), .sel_src(sel_src),
    .dw_dst(dw_dst), .dw_addr(dw_addr), .lane_en(lane_en), .lane_din(lane_din),
    .lane_dout(lane_dout), .rd_addr(rd_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input string what, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
    int bad;
    bad = -1;
    checks++;
    for (int i = LANES - 1; i >= 0; i--) if (act[i*DW +: DW] != exp[i*DW +: DW]) bad = i;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s %s lane %0d actual=%0h expected=%0h", req, what, bad,
               act[bad*DW +: DW], exp[bad*DW +: DW]);
    end
  endtask

  function automatic logic [VW-1:0] mem_view(input int a);
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = m_mem[i][a];
    return v;
  endfunction

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmd_op = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_mem(input string req, input int a);
    rd_addr = AW'(a);
    @(negedge clk);
    chk_vec(req, $sformatf("memory addr %0d", a), mem_rdata, mem_view(a));
  endtask

  // R1
  task automatic t_reset();
    chk_vec("R1", "lane words after reset", lane_dout, '0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    check_mem("R1", 0);
    check_mem("R1", DEPTH - 1);
  endtask

  // R2, R6
  task automatic t_load();
    for (int i = 0; i < LANES; i++) lane_din[i*DW +: DW] = DW'(i * 3 + 1);
    lane_en = '1;
    issue(2'd0);
    m_lanes = lane_din;
    chk_vec("R2", "full load", lane_dout, m_lanes);
    for (int i = 0; i < LANES; i++) begin
      lane_din[i*DW +: DW] = DW'(16'hA000 + i);
      lane_en[i] = (i % 2 == 0);
    end
    issue(2'd0);
    for (int i = 0; i < LANES; i += 2) m_lanes[i*DW +: DW] = lane_din[i*DW +: DW];
    chk_vec("R6", "masked load keeps odd lanes", lane_dout, m_lanes);
    lane_en = '1;
  endtask

  // R3, R4, R6
  task automatic t_shift();
    logic [VW-1:0] prev;
    prev = m_lanes;
    shift_up = 1'b1;
    edge_word = 16'hBEEF;
    issue(2'd1);
    m_lanes[0 +: DW] = 16'hBEEF;
    for (int i = 1; i < LANES; i++) m_lanes[i*DW +: DW] = prev[(i-1)*DW +: DW];
    chk_vec("R3", "shift up with edge fill", lane_dout, m_lanes);
    prev = m_lanes;
    shift_up = 1'b0;
    edge_word = 16'h0000;
    issue(2'd1);
    for (int i = 0; i < LANES - 1; i++) m_lanes[i*DW +: DW] = prev[(i+1)*DW +: DW];
    m_lanes[(LANES-1)*DW +: DW] = 16'h0000;
    chk_vec("R4", "shift down with edge fill", lane_dout, m_lanes);
    prev = m_lanes;
    lane_en = '1;
    lane_en[0] = 1'b0;
    lane_en[10] = 1'b0;
    shift_up = 1'b1;
    edge_word = 16'h1234;
    issue(2'd1);
    for (int i = 1; i < LANES; i++)
      if (i != 10) m_lanes[i*DW +: DW] = prev[(i-1)*DW +: DW];
    chk_vec("R6", "masked shift up", lane_dout, m_lanes);
    lane_en = '1;
  endtask

  // R5, R6
  task automatic t_bcast();
    logic [DW-1:0] w;
    w = m_lanes[5*DW +: DW];
    sel_src = LW'(5);
    issue(2'd2);
    for (int i = 0; i < LANES; i++) m_lanes[i*DW +: DW] = w;
    chk_vec("R5", "broadcast from lane 5", lane_dout, m_lanes);
    for (int i = 0; i < LANES; i++) lane_din[i*DW +: DW] = DW'(16'h3000 + i * 7);
    issue(2'd0);
    m_lanes = lane_din;
    w = m_lanes[(LANES-1)*DW +: DW];
    sel_src = LW'(LANES - 1);
    for (int i = 0; i < LANES; i++) lane_en[i] = (i % 3 != 0);
    issue(2'd2);
    for (int i = 0; i < LANES; i++) if (i % 3 != 0) m_lanes[i*DW +: DW] = w;
    chk_vec("R5", "masked broadcast from top lane", lane_dout, m_lanes);
    lane_en = '1;
  endtask

  // R7, R10: run one direct write and follow busy and done
  task automatic run_dwrite(input int src, input int dst, input int a, input string req);
    int n;
    logic [DW-1:0] w;
    w = m_lanes[src*DW +: DW];
    sel_src = LW'(src);
    dw_dst = LW'(dst);
    dw_addr = AW'(a);
    issue(2'd3);
    n = 0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk("R7", "busy length", n, DW_LAT);
    chk("R7", "done after busy", done, 1);
    if (lane_en[dst]) m_mem[dst][a] = w;
    chk_vec("R10", "lane words after direct write", lane_dout, m_lanes);
    @(negedge clk);
    chk("R7", "done lasts one cycle", done, 0);
    check_mem(req, a);
  endtask

  task automatic t_dwrite();
    run_dwrite(3, 10, 2, "R7");
    check_mem("R7", 0);
    run_dwrite(LANES - 1, 0, DEPTH - 1, "R7");
    run_dwrite(7, 7, 4, "R9");
    lane_en = '1;
    lane_en[20] = 1'b0;
    run_dwrite(1, 20, 2, "R6");
    lane_en = '1;
  endtask

  // R8
  task automatic t_busy_ignore();
    sel_src = LW'(2);
    dw_dst = LW'(30);
    dw_addr = AW'(5);
    m_mem[30][5] = m_lanes[2*DW +: DW];
    issue(2'd3);
    for (int i = 0; i < LANES; i++) lane_din[i*DW +: DW] = 16'hDEAD;
    cmd_op = 2'd0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 2'd3;
    dw_dst = LW'(31);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk_vec("R8", "load during busy ignored", lane_dout, m_lanes);
    check_mem("R8", 5);
  endtask

  initial begin
    for (int i = 0; i < LANES; i++)
      for (int a = 0; a < DEPTH; a++) m_mem[i][a] = '0;
    m_lanes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_shift();
    t_bcast();
    t_dwrite();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule